// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

The block watches a bank of interrupt request lines and chooses one of them to hand to the processor. A line is a candidate when it is pending and enabled. Among the candidates, the one with the most urgent priority wins. The winner is shown on a registered request output, together with its line number and a vector address that software can rewrite. Software reaches the per-line state through a word-addressed register port. Through this port it can:

- read and write the enable mask;
- force pending bits or drop them;
- read and write the 3-bit priority of each line;
- read and write the vector address of each line.

The processor takes the request with an acknowledge and ends the handler with a completion strobe. Between those two events the controller is in service. While in service, only lines more urgent than the one being serviced may raise a new request. This allows one level of pre-emption without any further nesting logic.

Register map (byte-free word addresses on an 8-bit address):

| Address | Register |
|---|---|
| 0x00 | Enable mask |
| 0x01 | Pending set (write 1s); reads pending |
| 0x02 | Pending clear (write 1s); reads pending |
| 0x40+n | Priority of line n (bits [2:0]) |
| 0x80+n | Vector of line n (bits [VEC_W-1:0]) |

Top module: `vic_top`

## Requirements
- R1: After a synchronous reset, cpu_req is 0 and every enable bit, pending bit, priority and vector reads back as 0.
- R2: A 0-to-1 transition on irq_in[n] sets pending bit n on the next clock. A line held steadily high does not set the bit again once it has been cleared.
- R3: Writing address 0x01 sets the pending bits where the data has a 1. Writing address 0x02 clears those bits. When a set (hardware edge or software) and a clear hit the same bit in one cycle, the bit ends up set.
- R4: Address 0x00 holds the enable mask, bit n for line n, and it is readable. A pending line whose enable bit is 0 is never requested.
- R5: Address 0x40+n holds the priority of line n in bits [2:0] and is readable. Value 0 is the most urgent and 7 the least. Rewriting a priority changes the selection at the next clock.
- R6: Among eligible lines of equal priority, the lowest line index is presented.
- R7: Address 0x80+n holds the vector of line n and is readable. When cpu_req is 1, cpu_vec equals the vector of line cpu_id, including right after that vector is rewritten.
- R8: cpu_req, cpu_id and cpu_vec are registered. They reflect the state produced by each clock edge at that same edge, so a state change made at edge k is visible on the outputs at edge k. With no pending enabled line, cpu_req is 0.
- R9: cpu_ack while cpu_req is 1 clears the pending bit of line cpu_id. cpu_ack while cpu_req is 0 changes nothing.
- R10: An accepted acknowledge starts service at the acknowledged line's priority. While in service, only lines with a strictly smaller priority number are requested. cpu_done ends service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Interrupt request lines, edge sensitive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| cpu_req | output | 1 | Interrupt request to the processor |
| cpu_id | output | 5 | Line number being presented |
| cpu_vec | output | 16 | Vector address of the presented line |
| cpu_ack | input | 1 | Processor accepts the presented line |
| cpu_done | input | 1 | Processor finished servicing |

## Verification
The bench targets these corner cases:

- Two equal-priority lines that rise together. A tie-break done the wrong way would present line 9 instead of line 7.
- An acknowledge followed by a less urgent pending line. It must stay masked until completion; a design that forgot the service level would re-request at once.
- An acknowledge of a more urgent line during service.
- An acknowledge given with no request. A design that did not qualify the acknowledge would lose a pending bit.
- An edge arriving in the same cycle as a software clear, where the set must win.
- A steadily high line after a clear, which must not be re-latched.
- A rewrite of the presented line's vector.
- A priority swap that must re-rank at once.

A behavioural model then compares request, line and vector on every cycle under several thousand cycles of random traffic.

// File: rtl/vic_pkg.sv
package vic_pkg;

    localparam int PRIO_W = 3;
    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        GRP_CTRL = 2'b00,
        GRP_PRIO = 2'b01,
        GRP_VEC  = 2'b10,
        GRP_NONE = 2'b11
    } reg_grp_e;

    localparam logic [5:0] OFS_ENABLE = 6'd0;
    localparam logic [5:0] OFS_SET    = 6'd1;
    localparam logic [5:0] OFS_CLEAR  = 6'd2;

    typedef struct packed {
        logic              active;
        logic [PRIO_W-1:0] level;
    } svc_t;

    function automatic reg_grp_e grp_of(input logic [ADDR_W-1:0] a);
        return reg_grp_e'(a[7:6]);
    endfunction

    // Priority numbers below this value may be requested.
    function automatic logic [PRIO_W:0] ceiling(input svc_t s);
        return s.active ? {1'b0, s.level} : {1'b1, {PRIO_W{1'b0}}};
    endfunction

endpackage

// File: rtl/vic_regfile.sv
module vic_regfile
    import vic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int VEC_W     = 16,
    parameter int DATA_W    = 32
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_LINES-1:0]             irq_in,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wr_data,
    input  logic [NUM_LINES-1:0]             ack_clr,
    output logic [DATA_W-1:0]                rd_data,
    output logic [NUM_LINES-1:0]             en_q,
    output logic [NUM_LINES-1:0]             pend_q,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q,
    output logic [NUM_LINES-1:0][VEC_W-1:0]  vec_q,
    output logic [NUM_LINES-1:0]             en_n,
    output logic [NUM_LINES-1:0]             pend_n,
    output logic [NUM_LINES-1:0][PRIO_W-1:0] prio_n,
    output logic [NUM_LINES-1:0][VEC_W-1:0]  vec_n,
    output logic [NUM_LINES-1:0]             set_mask
);

    logic [NUM_LINES-1:0] irq_prev;
    logic [NUM_LINES-1:0] sw_set, sw_clr, rise;
    reg_grp_e             grp;
    logic [5:0]           idx;

    assign grp  = grp_of(addr);
    assign idx  = addr[5:0];
    assign rise = irq_in & ~irq_prev;

    always_comb begin
        en_n   = en_q;
        sw_set = '0;
        sw_clr = '0;
        if (wr_en && grp == GRP_CTRL) begin
            if (idx == OFS_ENABLE) en_n   = wr_data[NUM_LINES-1:0];
            if (idx == OFS_SET)    sw_set = wr_data[NUM_LINES-1:0];
            if (idx == OFS_CLEAR)  sw_clr = wr_data[NUM_LINES-1:0];
        end
        set_mask = sw_set | rise;
        pend_n   = (pend_q & ~sw_clr & ~ack_clr) | set_mask;
    end

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        always_comb begin
            prio_n[i] = prio_q[i];
            vec_n[i]  = vec_q[i];
            if (wr_en && idx == 6'(i)) begin
                if (grp == GRP_PRIO) prio_n[i] = wr_data[PRIO_W-1:0];
                if (grp == GRP_VEC)  vec_n[i]  = wr_data[VEC_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                prio_q[i] <= '0;
                vec_q[i]  <= '0;
            end else begin
                prio_q[i] <= prio_n[i];
                vec_q[i]  <= vec_n[i];
            end
        end

        assert_edge_sets_R2: assert property (@(posedge clk) disable iff (rst)
            (irq_in[i] && !irq_prev[i]) |=> pend_q[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            pend_q   <= '0;
            irq_prev <= '0;
        end else begin
            en_q     <= en_n;
            pend_q   <= pend_n;
            irq_prev <= irq_in;
        end
    end

    always_comb begin
        rd_data = '0;
        case (grp)
            GRP_CTRL: begin
                if (idx == OFS_ENABLE) rd_data = DATA_W'(en_q);
                if (idx == OFS_SET || idx == OFS_CLEAR) rd_data = DATA_W'(pend_q);
            end
            GRP_PRIO: for (int i = 0; i < NUM_LINES; i++)
                if (idx == 6'(i)) rd_data = DATA_W'(prio_q[i]);
            GRP_VEC: for (int i = 0; i < NUM_LINES; i++)
                if (idx == 6'(i)) rd_data = DATA_W'(vec_q[i]);
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int VEC_W     = 16,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]             elig,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    input  logic [NUM_LINES-1:0][VEC_W-1:0]  vec,
    input  logic [PRIO_W:0]                  limit,
    output logic                             hit,
    output logic [ID_W-1:0]                  id,
    output logic [VEC_W-1:0]                 vec_o
);

    logic [PRIO_W:0] best;

    // Strict less-than keeps the lowest index on a tie.
    always_comb begin
        best = limit;
        hit  = 1'b0;
        id   = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (elig[i] && {1'b0, prio[i]} < best) begin
                best = {1'b0, prio[i]};
                hit  = 1'b1;
                id   = ID_W'(i);
            end
        end
        vec_o = vec[id];
    end

endmodule

// File: rtl/vic_top.sv
module vic_top
    import vic_pkg::*;
#(
    parameter int NUM_LINES = 32,
    parameter int VEC_W     = 16,
    parameter int DATA_W    = 32,
    localparam int ID_W     = $clog2(NUM_LINES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_LINES-1:0]  irq_in,
    input  logic                  reg_wr,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  cpu_req,
    output logic [ID_W-1:0]       cpu_id,
    output logic [VEC_W-1:0]      cpu_vec,
    input  logic                  cpu_ack,
    input  logic                  cpu_done
);

    logic [NUM_LINES-1:0]             en_q, pend_q, en_n, pend_n, set_mask, ack_clr;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q, prio_n;
    logic [NUM_LINES-1:0][VEC_W-1:0]  vec_q, vec_n;
    logic                             fire, hit;
    logic [ID_W-1:0]                  win_id;
    logic [VEC_W-1:0]                 win_vec;
    svc_t                             svc_q, svc_n;

    assign fire    = cpu_ack && cpu_req;
    assign ack_clr = fire ? (NUM_LINES'(1) << cpu_id) : '0;

    vic_regfile #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata),
        .ack_clr(ack_clr), .rd_data(reg_rdata),
        .en_q(en_q), .pend_q(pend_q), .prio_q(prio_q), .vec_q(vec_q),
        .en_n(en_n), .pend_n(pend_n), .prio_n(prio_n), .vec_n(vec_n),
        .set_mask(set_mask)
    );

    always_comb begin
        svc_n = svc_q;
        if (fire) begin
            svc_n.active = 1'b1;
            svc_n.level  = prio_q[cpu_id];
        end else if (cpu_done) begin
            svc_n = '0;
        end
    end

    // Selection runs on next-state values so outputs track state at the same edge.
    vic_arbiter #(.NUM_LINES(NUM_LINES), .VEC_W(VEC_W)) u_arb (
        .elig(pend_n & en_n), .prio(prio_n), .vec(vec_n),
        .limit(ceiling(svc_n)), .hit(hit), .id(win_id), .vec_o(win_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cpu_req <= 1'b0;
            cpu_id  <= '0;
            cpu_vec <= '0;
            svc_q   <= '0;
        end else begin
            cpu_req <= hit;
            cpu_id  <= win_id;
            cpu_vec <= win_vec;
            svc_q   <= svc_n;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> !cpu_req);

    assert_req_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> (pend_q[cpu_id] && en_q[cpu_id]));

    assert_vec_match_R7: assert property (@(posedge clk) disable iff (rst)
        cpu_req |-> cpu_vec == vec_q[cpu_id]);

    assert_idle_no_req_R8: assert property (@(posedge clk) disable iff (rst)
        ((pend_q & en_q) == '0) |-> !cpu_req);

    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (fire && !set_mask[cpu_id]) |=> !pend_q[$past(cpu_id)]);

    assert_preempt_only_R10: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && svc_q.active) |-> prio_q[cpu_id] < svc_q.level);

endmodule

// File: tb/sim_vic_top.sv
`timescale 1ns/1ps
module sim_vic_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] irq_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cpu_req;
    logic [4:0]  cpu_id;
    logic [15:0] cpu_vec;
    logic        cpu_ack = 1'b0;
    logic        cpu_done = 1'b0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    vic_top u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cpu_req(cpu_req), .cpu_id(cpu_id), .cpu_vec(cpu_vec),
        .cpu_ack(cpu_ack), .cpu_done(cpu_done)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_en, m_pend, m_prev;
    logic [2:0]  m_prio [32];
    logic [15:0] m_vec  [32];
    logic        m_act, m_req;
    logic [2:0]  m_lvl;
    logic [4:0]  m_id;
    logic [15:0] m_mvec;

    always @(posedge clk) begin
        if (rst) begin
            m_en = 0; m_pend = 0; m_prev = 0; m_act = 0; m_lvl = 0;
            m_req = 0; m_id = 0; m_mvec = 0;
            for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_vec[i] = 0; end
        end else begin
            logic [31:0] setm, clrm;
            int best;
            setm = irq_in & ~m_prev;
            clrm = 0;
            if (cpu_ack && m_req) begin
                clrm[m_id] = 1'b1;
                m_act = 1'b1;
                m_lvl = m_prio[m_id];
            end else if (cpu_done) begin
                m_act = 1'b0;
            end
            if (reg_wr) begin
                case (reg_addr[7:6])
                    2'd0: begin
                        if (reg_addr[5:0] == 0) m_en = reg_wdata;
                        if (reg_addr[5:0] == 1) setm = setm | reg_wdata;
                        if (reg_addr[5:0] == 2) clrm = clrm | reg_wdata;
                    end
                    2'd1: if (reg_addr[5:0] < 32) m_prio[reg_addr[4:0]] = reg_wdata[2:0];
                    2'd2: if (reg_addr[5:0] < 32) m_vec[reg_addr[4:0]] = reg_wdata[15:0];
                    default: ;
                endcase
            end
            m_pend = (m_pend & ~clrm) | setm;
            m_prev = irq_in;
            best = m_act ? int'(m_lvl) : 8;
            m_req = 0; m_id = 0;
            for (int i = 0; i < 32; i++)
                if (m_pend[i] && m_en[i] && int'(m_prio[i]) < best) begin
                    best = int'(m_prio[i]); m_req = 1; m_id = 5'(i);
                end
            m_mvec = m_vec[m_id];
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk("R8 cpu_req vs model", 32'(cpu_req), 32'(m_req));
            if (m_req) begin
                chk("R6 cpu_id vs model", 32'(cpu_id), 32'(m_id));
                chk("R7 cpu_vec vs model", 32'(cpu_vec), 32'(m_mvec));
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 cpu_req after reset", 32'(cpu_req), 0);
        rd(8'h00, d); chk("R1 enable after reset", d, 0);
        rd(8'h01, d); chk("R1 pending after reset", d, 0);
        rd(8'h45, d); chk("R1 priority after reset", d, 0);
        rd(8'h85, d); chk("R1 vector after reset", d, 0);

        for (int n = 0; n < 32; n++) wr(8'h80 + 8'(n), 32'h1000 + 32'(n * 4));
        wr(8'h43, 5); wr(8'h47, 2); wr(8'h49, 2); wr(8'h4C, 4); wr(8'h54, 0);
        rd(8'h47, d); chk("R5 priority readback", d, 2);
        rd(8'h89, d); chk("R7 vector readback", d, 32'h1024);

        irq_in[3] = 1'b1;
        @(negedge clk);
        rd(8'h01, d); chk("R2 edge sets pending", d, 32'h8);
        chk("R4 disabled line not requested", 32'(cpu_req), 0);

        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); chk("R4 enable readback", d, 32'hFFFF_FFFF);
        chk("R4 enabled line requested", 32'(cpu_id), 3);
        chk("R7 vector of line 3", 32'(cpu_vec), 32'h100C);

        irq_in[7] = 1'b1; irq_in[9] = 1'b1;
        @(negedge clk);
        chk("R6 tie goes to lower index", 32'(cpu_id), 7);

        ack();
        rd(8'h01, d); chk("R9 ack clears pending", d, 32'h208);
        chk("R10 equal priority masked in service", 32'(cpu_req), 0);
        wr(8'h01, 32'h0010_0000);
        chk("R10 more urgent line pre-empts", 32'(cpu_id), 20);
        ack();
        chk("R10 nested ack raises level", 32'(cpu_req), 0);
        cpu_done = 1'b1; @(negedge clk); cpu_done = 1'b0;
        chk("R10 done releases service", 32'(cpu_id), 9);
        chk("R10 request after done", 32'(cpu_req), 1);

        wr(8'h00, 0);
        ack();
        rd(8'h01, d); chk("R9 ack without request ignored", d, 32'h208);
        wr(8'h00, 32'hFFFF_FFFF);
        chk("R9 line still presented", 32'(cpu_id), 9);

        irq_in[12] = 1'b1;
        wr(8'h02, 32'h1000);
        rd(8'h01, d); chk("R3 set wins over clear", d[12], 1);
        wr(8'h02, 32'h1200);
        rd(8'h01, d); chk("R3 clear and R2 no relatch", d, 32'h8);
        chk("R3 remaining line presented", 32'(cpu_id), 3);

        wr(8'h83, 32'hBEEF);
        chk("R7 rewritten vector presented", 32'(cpu_vec), 32'hBEEF);

        wr(8'h01, 32'h1000);
        chk("R5 more urgent line wins", 32'(cpu_id), 12);
        wr(8'h4C, 6);
        chk("R5 priority rewrite reranks", 32'(cpu_id), 3);

        for (int k = 0; k < 4000; k++) begin
            int g;
            if ($urandom % 4 == 0) irq_in = irq_in ^ (32'd1 << ($urandom % 32));
            cpu_ack  = cpu_req && ($urandom % 4 == 0);
            cpu_done = ($urandom % 8 == 0);
            reg_wr   = ($urandom % 3 == 0);
            g = $urandom % 3;
            reg_addr = {2'(g), (g == 0) ? 6'($urandom % 3) : 6'($urandom % 32)};
            reg_wdata = (g == 0 && reg_addr[5:0] != 0) ? (32'd1 << ($urandom % 32)) : $urandom;
            @(negedge clk);
        end
        reg_wr = 1'b0; cpu_ack = 1'b0; cpu_done = 1'b0;
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule